// File: doc/BRIEF.md
# Multicarrier PWM Comparator Bank

This block makes the four gate-decision bits for one phase leg of a five-level cascaded bridge inverter. One phase counter runs the carriers. From it the block derives four triangular carriers, all with the same band height. Each cycle it compares a held, signed reference sample against every carrier. A bit is set when the reference is strictly above its carrier. The number of set bits, less two, is the signed output level in the range -2 to +2.

A two-bit layout input chooses how the four carriers are arranged. In the stacked layout, four in-phase bands are piled symmetrically about zero. In the rotated layout, four full-range carriers are spaced a quarter period apart. The dual-rate layout is the stacked one, except that the two inner bands run at twice the carrier rate, which evens out how often each switch toggles. In the overlapped layout, the bands are shifted by half a band from one another. The carrier size is set by `car_qtr` (Q): a band is 4Q counts high, a carrier period is 8Q cycles, and the reference full scale is ±8Q. The layout and Q are taken only at a period boundary.

Top module: `mcpwm_bank`

## Requirements
- R1: Bit k of `gate_bits` is 1 exactly when the held reference is strictly greater, as a signed number, than carrier k. Otherwise it is 0.
- R2: A phase counter p runs 0, 1, ..., 8Q-1 and wraps to 0. The fold of any phase x is tri(x) = x for x < 4Q, and 8Q - x otherwise. Outputs in the cycle after a clock edge reflect the p held before that edge.
- R3: Layout code 0 (stacked): carrier k = tri(p) + (k-2)*4Q.
- R4: Layout code 1 (rotated): carrier k = 4*tri(x_k) - 8Q, where x_k = (p + 2Q*k) mod 8Q.
- R5: Layout code 2 (dual-rate): carriers 0 and 3 are the same as in code 0. Carriers 1 and 2 are tri(2p mod 8Q) + (k-2)*4Q.
- R6: Layout code 3 (overlapped): carrier k = tri(p) + Q*(2k-5). Neighbouring bands overlap by 2Q, half a band.
- R7: `level` is a 3-bit two's-complement value. It equals the number of set bits in `gate_bits` minus 2, and it is registered in the same cycle as those bits.
- R8: The reference is captured only on edges where p is 0 or 4Q. Changes to `ref_in` at any other edge have no effect on the outputs.
- R9: `layout` and `car_qtr` are captured only on the edge where p wraps from 8Q-1 to 0. Changes at other edges have no effect until then.
- R10: A synchronous reset clears `gate_bits` to 0, sets `level` to -2, sets p and the held reference to 0, and captures `layout` and `car_qtr`.
- R11: In every layout except code 1, `gate_bits` is thermometer coded: bit k is set only if bit k-1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_qtr | input | QW | Carrier quarter-size Q (at least 1) |
| ref_in | input | RW | Signed reference sample |
| layout | input | 2 | Carrier layout code |
| gate_bits | output | 4 | Registered comparison bits, bit k for carrier k |
| level | output | 3 | Registered signed output level, -2 to +2 |

## Verification
The assertions assume two things about the inputs. First, `car_qtr` is never zero, so the phase bound and the wrap point are defined. Second, the reference stays within ±8Q plus a small margin, so the thermometer ordering reflects the carrier bands rather than sign-extension wrap. The stimulus keeps Q between 1 and 3 and draws each reference from a stride sweep over -8Q-1 to 8Q+1. That range covers both clipping extremes, and the reference changes on every cycle, so most of the applied values fall on edges where they must be ignored. Layout and Q changes are applied away from the wrap point, so the deferral is exercised together with the held-reference rule.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam int NUM_CAR = 4;

  typedef enum logic [1:0] {
    LAY_STACK = 2'd0,
    LAY_SHIFT = 2'd1,
    LAY_DUAL  = 2'd2,
    LAY_OVLP  = 2'd3
  } layout_e;
endpackage

// File: rtl/mcpwm_phase.sv
module mcpwm_phase #(
  parameter int QW = 8,
  parameter int RW = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [QW-1:0]             car_qtr,
  input  logic [1:0]                layout,
  input  logic signed [RW-1:0]      ref_in,
  output logic [QW+2:0]             ph,
  output logic [QW-1:0]             q_q,
  output mcpwm_pkg::layout_e        lay_q,
  output logic signed [RW-1:0]      ref_q
);
  localparam int PW = QW + 3;

  logic [PW-1:0] last_ph;
  logic [PW-1:0] mid_ph;
  logic          wrap;
  logic          sample;

  always_comb begin
    last_ph = {q_q, 3'b000} - PW'(1);
    mid_ph  = {1'b0, q_q, 2'b00};
    wrap    = (ph >= last_ph);
    sample  = (ph == '0) || (ph == mid_ph);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      q_q   <= car_qtr;
      lay_q <= mcpwm_pkg::layout_e'(layout);
      ref_q <= '0;
    end else begin
      if (wrap) begin
        ph    <= '0;
        q_q   <= car_qtr;
        lay_q <= mcpwm_pkg::layout_e'(layout);
      end else begin
        ph <= ph + PW'(1);
      end
      if (sample) ref_q <= ref_in;
    end
  end
endmodule

// File: rtl/mcpwm_carrier.sv
module mcpwm_carrier #(
  parameter int QW  = 8,
  parameter int CW  = 14,
  parameter int IDX = 0
) (
  input  logic [QW+2:0]             ph,
  input  logic [QW-1:0]             q_q,
  input  mcpwm_pkg::layout_e        lay_q,
  input  logic signed [CW-1:0]      ref_s,
  output logic                      above
);
  import mcpwm_pkg::*;

  localparam int PW = QW + 3;
  localparam logic signed [CW-1:0] K_STK = CW'(IDX - 2);
  localparam logic signed [CW-1:0] K_OVL = CW'(2 * IDX - 5);
  localparam logic [PW:0]          IDX_V = (PW+1)'(IDX);
  localparam bit                   IS_MID = (IDX == 1) || (IDX == 2);

  logic [PW:0] span, half, ph_x, sum, pk, tri_u;
  logic signed [CW-1:0] tri_s, half_s, q_s, car;

  always_comb begin
    span = {1'b0, q_q, 3'b000};
    half = {2'b00, q_q, 2'b00};
    ph_x = {1'b0, ph};
    sum  = '0;
    pk   = ph_x;
    case (lay_q)
      LAY_SHIFT: begin
        sum = ph_x + ({3'b000, q_q, 1'b0} * IDX_V);
        pk  = (sum >= span) ? (sum - span) : sum;
      end
      LAY_DUAL: begin
        if (IS_MID) begin
          sum = {ph, 1'b0};
          pk  = (sum >= span) ? (sum - span) : sum;
        end
      end
      default: pk = ph_x;
    endcase
    tri_u  = (pk < half) ? pk : (span - pk);
    tri_s  = $signed(CW'(tri_u));
    half_s = $signed(CW'(half));
    q_s    = $signed(CW'(q_q));
    case (lay_q)
      LAY_SHIFT: car = (tri_s <<< 2) - (half_s <<< 1);
      LAY_OVLP:  car = tri_s + q_s * K_OVL;
      default:   car = tri_s + half_s * K_STK;
    endcase
    above = (ref_s > car);
  end
endmodule

// File: rtl/mcpwm_bank.sv
module mcpwm_bank #(
  parameter int QW = 8,
  parameter int RW = 12
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [QW-1:0]                    car_qtr,
  input  logic signed [RW-1:0]             ref_in,
  input  logic [1:0]                       layout,
  output logic [mcpwm_pkg::NUM_CAR-1:0]    gate_bits,
  output logic signed [2:0]                level
);
  localparam int NC = mcpwm_pkg::NUM_CAR;
  localparam int PW = QW + 3;
  localparam int CW = ((RW > QW + 5) ? RW : QW + 5) + 1;

  logic [PW-1:0]          ph;
  logic [QW-1:0]          q_q;
  mcpwm_pkg::layout_e     lay_q;
  logic signed [RW-1:0]   ref_q;
  logic signed [CW-1:0]   ref_s;
  logic [NC-1:0]          cmp;
  logic [2:0]             cnt;
  logic signed [2:0]      lvl_next;

  mcpwm_phase #(.QW(QW), .RW(RW)) u_phase (
    .clk(clk), .rst(rst), .car_qtr(car_qtr), .layout(layout),
    .ref_in(ref_in), .ph(ph), .q_q(q_q), .lay_q(lay_q), .ref_q(ref_q)
  );

  assign ref_s = CW'(ref_q);

  for (genvar k = 0; k < NC; k++) begin : g_car
    mcpwm_carrier #(.QW(QW), .CW(CW), .IDX(k)) u_car (
      .ph(ph), .q_q(q_q), .lay_q(lay_q), .ref_s(ref_s), .above(cmp[k])
    );
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NC; k++) cnt = cnt + 3'(cmp[k]);
    lvl_next = $signed(cnt - 3'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_bits <= '0;
      level     <= -3'sd2;
    end else begin
      gate_bits <= cmp;
      level     <= lvl_next;
    end
  end
endmodule

// File: rtl/mcpwm_bank_chk.sv
module mcpwm_bank_chk #(
  parameter int QW = 8,
  parameter int RW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           gate_bits,
  input logic signed [2:0]    level,
  input logic [QW+2:0]        ph,
  input logic [QW-1:0]        q_q,
  input logic [1:0]           lay_q,
  input logic signed [RW-1:0] ref_q
);
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_bits == 4'b0000 && level == -3'sd2));

  // R7
  level_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_bits) == int'(level) + 2);

  // R11
  thermo_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lay_q) != 2'd1) |-> ((gate_bits & ~{gate_bits[2:0], 1'b1}) == 4'b0000));

  // R9
  layout_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lay_q) || !$stable(q_q)) |-> (ph == '0));

  // R8
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_q) |-> ($past(ph) == '0 || $past(ph) == {1'b0, $past(q_q), 2'b00}));

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (q_q != '0) |-> (ph < {q_q, 3'b000}));
endmodule

bind mcpwm_bank mcpwm_bank_chk #(.QW(QW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .gate_bits(gate_bits), .level(level),
  .ph(ph), .q_q(q_q), .lay_q(lay_q), .ref_q(ref_q)
);

// File: tb/mcpwm_bank_bench.sv
`timescale 1ns/1ps
module mcpwm_bank_bench;
  localparam int QW = 8;
  localparam int RW = 12;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [QW-1:0]        car_qtr = 8'd2;
  logic signed [RW-1:0] ref_in = '0;
  logic [1:0]           layout = 2'd0;
  logic [3:0]           gate_bits;
  logic signed [2:0]    level;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int ph_m = 0, q_m = 2, lay_m = 0, ref_m = 0;
  logic [3:0] exp_bits = 4'b0000;
  int exp_lay = 0;

  always #10 clk = ~clk;

  mcpwm_bank #(.QW(QW), .RW(RW)) u_mcpwm_bank (
    .clk(clk), .rst(rst), .car_qtr(car_qtr), .ref_in(ref_in),
    .layout(layout), .gate_bits(gate_bits), .level(level)
  );

  function automatic int fold(int x, int q);
    return (x < 4 * q) ? x : 8 * q - x;
  endfunction

  function automatic logic [3:0] model_bits(int ph, int q, int lay, int r);
    logic [3:0] b;
    for (int k = 0; k < 4; k++) begin
      int x, c;
      x = ph;
      if (lay == 1) x = (ph + 2 * q * k) % (8 * q);
      if (lay == 2 && (k == 1 || k == 2)) x = (2 * ph) % (8 * q);
      if (lay == 1)      c = 4 * fold(x, q) - 8 * q;
      else if (lay == 3) c = fold(x, q) + q * (2 * k - 5);
      else               c = fold(x, q) + 4 * q * (k - 2);
      b[k] = (r > c);
    end
    return b;
  endfunction

  task automatic step(input bit r_rst, input int r_lay, input int r_q, input int r_ref,
                      input string tag);
    int cnt;
    rst     = r_rst;
    layout  = 2'(r_lay);
    car_qtr = QW'(r_q);
    ref_in  = RW'(r_ref);
    if (r_rst) begin
      exp_bits = 4'b0000;
      exp_lay  = 0;
      ph_m = 0; q_m = r_q; lay_m = r_lay; ref_m = 0;
    end else begin
      exp_bits = model_bits(ph_m, q_m, lay_m, ref_m);
      exp_lay  = lay_m;
      if (ph_m == 0 || ph_m == 4 * q_m) ref_m = r_ref;
      if (ph_m >= 8 * q_m - 1) begin
        ph_m = 0; q_m = r_q; lay_m = r_lay;
      end else begin
        ph_m = ph_m + 1;
      end
    end
    @(negedge clk);
    cnt = $countones(exp_bits);
    checks++;
    if (gate_bits !== exp_bits) begin
      fails++;
      $display("FAIL %s gate_bits actual %b expected %b", tag, gate_bits, exp_bits);
    end
    checks++;
    if (int'(level) != cnt - 2) begin
      fails++;
      $display("FAIL R7 level actual %0d expected %0d", level, cnt - 2);
    end
    if (!r_rst && exp_lay != 1) begin
      checks++;
      if ((gate_bits & ~{gate_bits[2:0], 1'b1}) != 4'b0000) begin
        fails++;
        $display("FAIL R11 gate_bits actual %b expected thermometer", gate_bits);
      end
    end
  endtask

  function automatic string lay_tag(int lay);
    case (lay)
      0: return "R1 R2 R3 R8 R9";
      1: return "R1 R2 R4 R8 R9";
      2: return "R1 R2 R5 R8 R9";
      default: return "R1 R2 R6 R8 R9";
    endcase
  endfunction

  initial begin
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 0, 2, 5, "R10");
    // sweeps over every layout and small Q; inputs change mid-period
    for (int lay = 0; lay < 4; lay++) begin
      for (int q = 1; q <= 3; q++) begin
        for (int n = 0; n < 8 * q * 3 + 5; n++) begin
          int r;
          r = ((n * 5 + lay * 3) % (16 * q + 3)) - 8 * q - 1;
          step(1'b0, lay, q, r, lay_tag(lay));
        end
      end
    end
    // R1 extremes: reference pinned at full scale
    for (int n = 0; n < 40; n++) step(1'b0, 0, 2, 16, "R1 R3");
    for (int n = 0; n < 40; n++) step(1'b0, 3, 2, -16, "R1 R6");
    // R10: reset in the middle of a period
    for (int n = 0; n < 13; n++) step(1'b0, 1, 2, n - 6, "R4 R8");
    for (int n = 0; n < 2; n++) step(1'b1, 2, 3, 9, "R10");
    for (int n = 0; n < 60; n++) step(1'b0, 2, 3, ((n * 7) % 51) - 25, "R5 R8 R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule